// File: doc/BRIEF.md
# Dual-Modulus Fractional Divider Controller

This block is the digital feedback divider of a fractional-N frequency synthesizer. It runs on the fast oscillator-side clock and splits that clock into divide periods. Each period lasts either P or P-1 input clocks. A first-order rational accumulator picks the length of each period so that, over a full sequence, the average ratio equals (P-1) + N/D exactly. Any rational value from P-1 up to P can therefore be reached without drift.

The block emits a single-cycle pulse at the first clock of every divide period. This is the edge that goes to the phase detector. Alongside the pulse it gives a flag that names the modulus chosen for the period that the pulse opens. The configuration (P, N and D) is taken in only on the clock that starts a period, so the running period always keeps the length it started with. The phase detector, charge pump, loop filter and oscillator sit outside this block.

Top module: `frac_div_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `div_pulse` and `mod_hi` are 0 after that edge. The first edge with `rst_n` high starts a period and raises `div_pulse`.
- R2: The number of clocks from one `div_pulse` to the next equals P when `mod_hi` was 1 at the first of the two pulses, and P-1 when it was 0.
- R3: After reset the accumulator holds 0. Each period start adds N. If the sum is at least D, D is subtracted and the period uses P (`mod_hi`=1); otherwise the sum is kept and the period uses P-1. With N equal to D every period uses P.
- R4: With N=0 and D>0 every period uses P-1.
- R5: With N/D = 1/2, periods alternate P-1, P, P-1, P and so on after reset. For P=5 each pair of periods spans 9 clocks.
- R6: With the configuration held since reset, any D consecutive periods together span exactly D*(P-1)+N clocks.
- R7: P, N and D are sampled only on the clock that starts a period. A change during a period does not alter its length and takes effect from the next period.
- R8: A programmed P below 3 is treated as 3.
- R9: N greater than D is treated as N=D. D=0 makes every period use P.
- R10: `div_pulse` is high for exactly one clock per period, and `mod_hi` changes only on a clock where `div_pulse` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-side clock being divided |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_p | input | P_W | Upper modulus P |
| cfg_num | input | FRAC_W | Fraction numerator N |
| cfg_den | input | FRAC_W | Fraction denominator D |
| div_pulse | output | 1 | One-clock pulse at the start of each divide period |
| mod_hi | output | 1 | 1 when the current period uses P, 0 when it uses P-1 |

## Verification
The hardest case to reach from the ports is a configuration change that lands in the middle of a period. The running period must keep its old length, and only the next one may change. The stimulus starts a long integer-ratio run, waits a few clocks past a pulse, then rewrites P, or separately N. It then checks the lengths of the periods on each side of the change. Each ratio case is also started from reset, so the accumulator starts at a known value, and every window of D periods is summed.

// File: rtl/frac_div_pkg.sv
// Shared constants for the dual-modulus fractional divider.
// Assumes nothing beyond IEEE 1800-2017.
package frac_div_pkg;

    // Smallest upper modulus accepted; lower programmed values are raised to it.
    localparam int MIN_MODULUS = 3;

    // Which of the two moduli a divide period uses.
    typedef enum logic {
        MOD_LOW  = 1'b0,   // divide by P-1
        MOD_HIGH = 1'b1    // divide by P
    } mod_sel_e;

endpackage

// File: rtl/frac_div_cfg_clamp.sv
// Legalises the raw configuration words.
// P is raised to the minimum modulus, and N is limited to D.
// A D of zero passes through; the accumulator then always picks P.
// Purely combinational.
module frac_div_cfg_clamp
    import frac_div_pkg::*;
#(
    parameter int P_W    = 8,
    parameter int FRAC_W = 12
) (
    input  logic [P_W-1:0]    raw_p_i,
    input  logic [FRAC_W-1:0] raw_num_i,
    input  logic [FRAC_W-1:0] raw_den_i,
    output logic [P_W-1:0]    p_o,
    output logic [FRAC_W-1:0] num_o,
    output logic [FRAC_W-1:0] den_o
);

    localparam logic [P_W-1:0] P_FLOOR = P_W'(MIN_MODULUS);

    // Apply the floor on P and the ceiling on N.
    always_comb begin
        p_o   = (raw_p_i < P_FLOOR) ? P_FLOOR : raw_p_i;
        num_o = (raw_num_i > raw_den_i) ? raw_den_i : raw_num_i;
        den_o = raw_den_i;
    end

endmodule

// File: rtl/frac_div_accum.sv
// First-order rational accumulator.
// On every period start (step_i) it adds the numerator.
// It requests the upper modulus when the sum reaches the denominator, and then subtracts the denominator.
// Assumes num_i <= den_i, so the state never grows.
module frac_div_accum
    import frac_div_pkg::*;
#(
    parameter int FRAC_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [FRAC_W-1:0] num_i,
    input  logic [FRAC_W-1:0] den_i,
    output mod_sel_e          pick_o
);

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W-1:0] acc_d;
    logic [FRAC_W:0]   sum;
    logic [FRAC_W:0]   diff;
    logic              reach;

    // Form the candidate sum and decide the modulus for the coming period.
    always_comb begin
        sum    = {1'b0, acc_q} + {1'b0, num_i};
        diff   = sum - {1'b0, den_i};
        reach  = (sum >= {1'b0, den_i});
        pick_o = reach ? MOD_HIGH : MOD_LOW;
        acc_d  = reach ? diff[FRAC_W-1:0] : sum[FRAC_W-1:0];
    end

    // Hold the residue between period starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (step_i) begin
            acc_q <= acc_d;
        end
    end

endmodule

// File: rtl/frac_div_modcnt.sv
// Dual-modulus down-counter.
// At the end of a period it loads P or P-1, as pick_i asks, and raises a single-cycle pulse.
// Assumes p_i >= 3, so both moduli are at least 2 clocks.
module frac_div_modcnt
    import frac_div_pkg::*;
#(
    parameter int P_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [P_W-1:0] p_i,
    input  mod_sel_e       pick_i,
    output logic           boundary_o,
    output logic           pulse_o,
    output mod_sel_e       mod_o
);

    localparam logic [P_W-1:0] ONE = P_W'(1);

    logic [P_W-1:0] cnt_q;
    logic [P_W-1:0] load_val;

    // A period ends when the counter is on its last clock, or right after reset.
    always_comb begin
        boundary_o = (cnt_q <= ONE);
        load_val   = (pick_i == MOD_HIGH) ? p_i : (p_i - ONE);
    end

    // Count down, reload at the boundary and flag the new period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pulse_o <= 1'b0;
            mod_o   <= MOD_LOW;
        end else if (boundary_o) begin
            cnt_q   <= load_val;
            pulse_o <= 1'b1;
            mod_o   <= pick_i;
        end else begin
            cnt_q   <= cnt_q - ONE;
            pulse_o <= 1'b0;
        end
    end

endmodule

// File: rtl/frac_div_ctrl.sv
// Top of the dual-modulus fractional divider controller.
// It divides clk by P or P-1 per period so that the average ratio is (P-1)+N/D.
// Configuration is consumed only on the clock that starts a period.
// Reset is synchronous and active low.
module frac_div_ctrl
    import frac_div_pkg::*;
#(
    parameter int P_W    = 8,
    parameter int FRAC_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [P_W-1:0]    cfg_p,
    input  logic [FRAC_W-1:0] cfg_num,
    input  logic [FRAC_W-1:0] cfg_den,
    output logic              div_pulse,
    output logic              mod_hi
);

    logic [P_W-1:0]    p_eff;
    logic [FRAC_W-1:0] num_eff;
    logic [FRAC_W-1:0] den_eff;
    logic              boundary;
    mod_sel_e          pick;
    mod_sel_e          mod_cur;

    frac_div_cfg_clamp #(.P_W(P_W), .FRAC_W(FRAC_W)) u_clamp (
        .raw_p_i   (cfg_p),
        .raw_num_i (cfg_num),
        .raw_den_i (cfg_den),
        .p_o       (p_eff),
        .num_o     (num_eff),
        .den_o     (den_eff)
    );

    frac_div_accum #(.FRAC_W(FRAC_W)) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (boundary),
        .num_i  (num_eff),
        .den_i  (den_eff),
        .pick_o (pick)
    );

    frac_div_modcnt #(.P_W(P_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .p_i        (p_eff),
        .pick_i     (pick),
        .boundary_o (boundary),
        .pulse_o    (div_pulse),
        .mod_o      (mod_cur)
    );

    // Present the modulus flag as a plain bit.
    assign mod_hi = (mod_cur == MOD_HIGH);

endmodule

// File: rtl/frac_div_ctrl_chk.sv
// Property checker for frac_div_ctrl, attached to it through bind.
// It keeps its own record of the configuration and of the period length.
module frac_div_ctrl_chk #(
    parameter int P_W    = 8,
    parameter int FRAC_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [P_W-1:0]    cfg_p,
    input logic [FRAC_W-1:0] cfg_num,
    input logic [FRAC_W-1:0] cfg_den,
    input logic              div_pulse,
    input logic              mod_hi
);

    logic [P_W-1:0]    last_p;
    logic [FRAC_W-1:0] last_n;
    logic [FRAC_W-1:0] last_d;
    logic              seen;
    logic [P_W:0]      gap;
    logic [P_W-1:0]    exp_len;
    logic [P_W-1:0]    p_fl;

    // Floor of 3 on the P value captured at the period start.
    assign p_fl = (last_p < P_W'(3)) ? P_W'(3) : last_p;

    // Record the configuration seen at each edge, the clocks since the last pulse, and the length owed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_p  <= '0;
            last_n  <= '0;
            last_d  <= '0;
            seen    <= 1'b0;
            gap     <= '0;
            exp_len <= '0;
        end else begin
            last_p <= cfg_p;
            last_n <= cfg_num;
            last_d <= cfg_den;
            if (div_pulse) begin
                seen    <= 1'b1;
                gap     <= (P_W+1)'(1);
                exp_len <= mod_hi ? p_fl : (p_fl - P_W'(1));
            end else begin
                gap <= gap + (P_W+1)'(1);
            end
        end
    end

    assert_period_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && div_pulse) |-> (gap == {1'b0, exp_len}));

    assert_full_ratio_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (div_pulse && (last_n >= last_d)) |-> mod_hi);   // also covers R9

    assert_zero_num_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_pulse && (last_n == '0) && (last_d != '0)) |-> !mod_hi);

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    assert_mod_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !div_pulse |-> $stable(mod_hi));

endmodule

bind frac_div_ctrl frac_div_ctrl_chk #(.P_W(P_W), .FRAC_W(FRAC_W)) u_chk (.*);

// File: tb/frac_div_ctrl_tb.sv
module frac_div_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int P_W        = 8;
    localparam int FRAC_W     = 12;
    localparam int WATCHDOG   = 50000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [P_W-1:0]    cfg_p = 8'd5;
    logic [FRAC_W-1:0] cfg_num = '0;
    logic [FRAC_W-1:0] cfg_den = 12'd1;
    logic              div_pulse;
    logic              mod_hi;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // Behavioural reference state.
    int m_rem = 0, m_acc = 0;
    bit m_pulse = 0, m_mod = 0, m_valid = 0;

    // Measured periods.
    int lens[$];
    int mods[$];
    int gap = 0;
    bit seen = 0;
    int pulses_seen = 0;

    frac_div_ctrl #(.P_W(P_W), .FRAC_W(FRAC_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_p     (cfg_p),
        .cfg_num   (cfg_num),
        .cfg_den   (cfg_den),
        .div_pulse (div_pulse),
        .mod_hi    (mod_hi)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Reference model: one update per rising edge from the requirement rules.
    always @(posedge clk) begin
        int pe, ne, de, s;
        if (!rst_n) begin
            m_rem = 0; m_acc = 0; m_pulse = 0; m_mod = 0;
        end else if (m_rem <= 1) begin
            pe = (cfg_p < 3) ? 3 : int'(cfg_p);
            de = int'(cfg_den);
            ne = (cfg_num > cfg_den) ? de : int'(cfg_num);
            s  = m_acc + ne;
            if (s >= de) begin
                m_mod = 1; m_acc = s - de; m_rem = pe;
            end else begin
                m_mod = 0; m_acc = s; m_rem = pe - 1;
            end
            m_pulse = 1;
        end else begin
            m_rem--; m_pulse = 0;
        end
        m_valid = 1;
    end

    // Compare on every clock and measure period lengths.
    always @(negedge clk) begin
        if (m_valid) begin
            check(cur_req, int'(div_pulse === 1'b1), int'(m_pulse));
            check(cur_req, int'(mod_hi === 1'b1), int'(m_mod));
        end
        if (!rst_n) begin
            seen = 0; gap = 0;
        end else if (div_pulse === 1'b1) begin
            if (seen) lens.push_back(gap);
            mods.push_back(int'(mod_hi));
            gap = 1; seen = 1;
            pulses_seen++;
        end else begin
            gap++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_vec++; n_bad++;
            $display("FAIL %s: watchdog actual %0d cycles expected below %0d", cur_req, cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Reset with a configuration, check the reset state and the first pulse (R1).
    task automatic start_run(int p, int n, int d);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_p = P_W'(p); cfg_num = FRAC_W'(n); cfg_den = FRAC_W'(d);
        repeat (3) @(negedge clk);
        check("R1", int'(div_pulse), 0);
        check("R1", int'(mod_hi), 0);
        lens.delete(); mods.delete();
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(div_pulse), 1);
    endtask

    // Sum every window of d periods among the first few (R6).
    task automatic window_check(int d, int exp_total);
        wait (lens.size() >= d + 3);
        for (int st = 0; st < 3; st++) begin
            int tot = 0;
            for (int k = 0; k < d; k++) tot += lens[st + k];
            check("R6", tot, exp_total);
        end
    endtask

    task automatic all_len(string req, int cnt, int exp_len, int exp_mod);
        wait (lens.size() >= cnt);
        for (int k = 0; k < cnt; k++) begin
            check(req, lens[k], exp_len);
            check(req, mods[k], exp_mod);
        end
    endtask

    initial begin
        // Half ratio, P=5 (R5).
        cur_req = "R5";
        start_run(5, 1, 2);
        wait (lens.size() >= 8);
        check("R5", mods[0], 0);
        check("R5", mods[1], 1);
        for (int k = 0; k < 4; k++) check("R5", lens[2*k] + lens[2*k+1], 9);
        window_check(2, 9);

        // Integer ratio N=D (R3).
        cur_req = "R3";
        start_run(7, 3, 3);
        all_len("R3", 6, 7, 1);
        window_check(3, 21);

        // Zero numerator (R4).
        cur_req = "R4";
        start_run(6, 0, 5);
        all_len("R4", 6, 5, 0);

        // Rational ratios, length against modulus (R2) and window sums (R6).
        cur_req = "R2";
        start_run(12, 3, 7);
        window_check(7, 80);
        cur_req = "R6";
        start_run(20, 5, 8);
        window_check(8, 157);
        cur_req = "R10";
        start_run(9, 4, 13);
        window_check(13, 108);

        // P floor (R8).
        cur_req = "R8";
        start_run(1, 2, 2);
        all_len("R8", 5, 3, 1);
        start_run(2, 0, 4);
        all_len("R8", 5, 2, 0);

        // N above D and D of zero (R9).
        cur_req = "R9";
        start_run(6, 9, 4);
        all_len("R9", 5, 6, 1);
        start_run(6, 5, 0);
        all_len("R9", 5, 6, 1);

        // Mid-period change of P, then of N (R7).
        cur_req = "R7";
        start_run(10, 1, 1);
        repeat (3) @(negedge clk);
        cfg_p = 8'd4;
        wait (lens.size() >= 3);
        check("R7", lens[0], 10);
        check("R7", lens[1], 4);
        check("R7", lens[2], 4);
        start_run(8, 0, 3);
        repeat (2) @(negedge clk);
        cfg_num = 12'd3;
        wait (lens.size() >= 2);
        check("R7", lens[0], 7);
        check("R7", lens[1], 8);

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule